// File: doc/BRIEF.md
# Debug-Transaction Access Bit Tracker

This block holds per-line access metadata for the small private cache of a core that runs hardware transactions. Every line carries a tag and four flags: a transactional read flag and a transactional write flag, plus a debug read flag and a debug write flag. Local loads and stores set these flags according to two mode flags. One mode flag says a transaction is open. The other says a debug transaction is collecting accesses. Conflict-detection logic elsewhere in the core reads the flags of any tag through a combinational probe port.

A command port carries the transaction primitives and the debug-transaction primitives: begin, commit and abort for transactions, and begin, end, pause, resume and clear for debug transactions. Debug transactions keep no checkpoint, so only their mode and the debug flags are tracked. Lines are matched by tag across the whole array. A miss fills the lowest-numbered invalid line. When no line is invalid, the miss replaces a line chosen round-robin. Replacing a line that holds transactional flags sets a sticky overflow flag. Replacing a line that holds only debug flags drops them silently.

Top module: `dbg_access_tracker`

## Requirements
- R1: After reset, every line is invalid, both mode outputs are 0, and `overflow_o` and `cmd_err_o` are 0.
- R2: While `tm_mode_o` is 1, an access with `acc_write_i`=0 sets the line's transactional read flag, and an access with `acc_write_i`=1 sets its transactional write flag. While `tm_mode_o` is 0, no transactional flag is set.
- R3: Transaction begin (op 0) sets `tm_mode_o`. Commit (op 1) and abort (op 2) each clear `tm_mode_o`, clear every transactional flag in one cycle, and clear `overflow_o`.
- R4: While `dtm_mode_o` is 1, a read sets the debug read flag and a write sets the debug write flag. While `dtm_mode_o` is 0, no debug flag is set.
- R5: Debug begin (op 3) sets `dtm_mode_o`. Debug end (op 4) clears `dtm_mode_o` and clears every debug flag.
- R6: Debug pause (op 5) clears `dtm_mode_o` and keeps all debug flags. Debug resume (op 6) sets `dtm_mode_o` again.
- R7: Debug clear (op 7) clears every debug flag in one cycle. It leaves the modes and the transactional flags unchanged.
- R8: A miss fills the lowest-index invalid line. When all lines are valid, the miss replaces the line at a round-robin pointer, which starts at line 0 and advances once per replacement. In the cycle of the replacement, `evict_o` is 1 and `evict_tag_o` shows the replaced tag.
- R9: Replacing a line whose transactional read or write flag is set makes `overflow_o` 1. It stays 1 until a commit or an abort.
- R10: Replacing a line that holds only debug flags drops those flags and leaves `overflow_o` unchanged.
- R11: The following commands are illegal, have no effect, and cause `cmd_err_o` to be 1 for the one cycle after they are issued: transaction begin while a transaction is open; commit or abort with no transaction open; debug begin while debug is running or paused; end with debug idle; pause unless debug is running; resume unless debug is paused.
- R12: When a flag clear and an access that would set the same kind of flag fall in the same cycle, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Local access strobe |
| acc_write_i | input | 1 | 1 = store, 0 = load |
| acc_tag_i | input | TAG_W | Line tag of the access |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command opcode (see R3, R5, R6, R7) |
| probe_tag_i | input | TAG_W | Tag to look up |
| probe_hit_o | output | 1 | Probe tag is held by a valid line |
| probe_r_o | output | 1 | Transactional read flag of the probed line |
| probe_w_o | output | 1 | Transactional write flag of the probed line |
| probe_dr_o | output | 1 | Debug read flag of the probed line |
| probe_dw_o | output | 1 | Debug write flag of the probed line |
| tm_mode_o | output | 1 | Transaction open |
| dtm_mode_o | output | 1 | Debug transaction collecting |
| overflow_o | output | 1 | Sticky transactional overflow |
| cmd_err_o | output | 1 | Illegal-command pulse |
| evict_o | output | 1 | This access replaces a valid line |
| evict_tag_o | output | TAG_W | Tag being replaced |

## Verification
The bench checks that pause keeps the debug flags and only blocks new ones. A design that cleared on pause would lose the flags on resume. A design that kept collecting during pause would show new debug flags on lines touched while paused. It replaces a line that holds transactional flags and a line that holds only debug flags. A design that treated these the same would raise overflow in the wrong case or miss it in the right one. It also checks that commit clears overflow and clears the transactional flags but not the debug flags. It issues each illegal command in turn and expects an error pulse with the state unchanged. It drives debug end in the same cycle as a store and expects no debug flag to survive.

// File: rtl/tracker_pkg.sv
package tracker_pkg;

  typedef enum logic [2:0] {
    OP_TX_BEGIN   = 3'd0,
    OP_TX_COMMIT  = 3'd1,
    OP_TX_ABORT   = 3'd2,
    OP_DBG_BEGIN  = 3'd3,
    OP_DBG_END    = 3'd4,
    OP_DBG_PAUSE  = 3'd5,
    OP_DBG_RESUME = 3'd6,
    OP_DBG_CLEAR  = 3'd7
  } cmd_op_e;

  typedef enum logic [1:0] {
    DBG_IDLE   = 2'd0,
    DBG_RUN    = 2'd1,
    DBG_PAUSED = 2'd2
  } dbg_state_e;

  typedef struct packed {
    logic r;
    logic w;
    logic dr;
    logic dw;
  } acc_bits_t;

endpackage

// File: rtl/tracker_mode_ctrl.sv
module tracker_mode_ctrl
  import tracker_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic [2:0] cmd_op_i,
  output logic       tm_o,
  output logic       dtm_o,
  output logic       dbg_active_o,
  output logic       clr_tx_o,
  output logic       clr_dbg_o,
  output logic       err_o
);

  dbg_state_e dbg_q, dbg_d;
  logic       tm_q, tm_d;
  logic       legal;
  cmd_op_e    op;

  assign op = cmd_op_e'(cmd_op_i);

  always_comb begin
    legal = 1'b0;
    tm_d  = tm_q;
    dbg_d = dbg_q;
    unique case (op)
      OP_TX_BEGIN:   begin legal = !tm_q;                tm_d = 1'b1;    end
      OP_TX_COMMIT,
      OP_TX_ABORT:   begin legal = tm_q;                 tm_d = 1'b0;    end
      OP_DBG_BEGIN:  begin legal = (dbg_q == DBG_IDLE);  dbg_d = DBG_RUN;    end
      OP_DBG_END:    begin legal = (dbg_q != DBG_IDLE);  dbg_d = DBG_IDLE;   end
      OP_DBG_PAUSE:  begin legal = (dbg_q == DBG_RUN);   dbg_d = DBG_PAUSED; end
      OP_DBG_RESUME: begin legal = (dbg_q == DBG_PAUSED); dbg_d = DBG_RUN;   end
      OP_DBG_CLEAR:  legal = 1'b1;
      default:       legal = 1'b0;
    endcase
  end

  assign clr_tx_o  = cmd_valid_i && legal && (op == OP_TX_COMMIT || op == OP_TX_ABORT);
  assign clr_dbg_o = cmd_valid_i && legal && (op == OP_DBG_END || op == OP_DBG_CLEAR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tm_q  <= 1'b0;
      dbg_q <= DBG_IDLE;
      err_o <= 1'b0;
    end else begin
      err_o <= cmd_valid_i && !legal;
      if (cmd_valid_i && legal) begin
        tm_q  <= tm_d;
        dbg_q <= dbg_d;
      end
    end
  end

  assign tm_o         = tm_q;
  assign dtm_o        = (dbg_q == DBG_RUN);
  assign dbg_active_o = (dbg_q != DBG_IDLE);

  p_err_after_cmd_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(cmd_valid_i));

  p_dtm_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dtm_o) |-> $past(cmd_valid_i && (cmd_op_i == 3'd3 || cmd_op_i == 3'd6)));

  p_dtm_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dtm_o) |-> $past(cmd_valid_i && (cmd_op_i == 3'd4 || cmd_op_i == 3'd5)));

  p_tm_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tm_o) |-> $past(cmd_valid_i && cmd_op_i == 3'd0));

endmodule

// File: rtl/tracker_line.sv
module tracker_line
  import tracker_pkg::*;
#(
  parameter int unsigned TAG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  logic [TAG_W-1:0] alloc_tag_i,
  input  acc_bits_t        set_i,
  input  logic             clr_tx_i,
  input  logic             clr_dbg_i,
  output logic             valid_o,
  output logic [TAG_W-1:0] tag_o,
  output acc_bits_t        bits_o
);

  acc_bits_t base, bits_d;

  always_comb begin
    base      = alloc_i ? '0 : bits_o;
    bits_d.r  = clr_tx_i  ? 1'b0 : (base.r  | set_i.r);
    bits_d.w  = clr_tx_i  ? 1'b0 : (base.w  | set_i.w);
    bits_d.dr = clr_dbg_i ? 1'b0 : (base.dr | set_i.dr);
    bits_d.dw = clr_dbg_i ? 1'b0 : (base.dw | set_i.dw);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      tag_o   <= '0;
      bits_o  <= '0;
    end else begin
      if (alloc_i) begin
        valid_o <= 1'b1;
        tag_o   <= alloc_tag_i;
      end
      bits_o <= bits_d;
    end
  end

  p_line_dbg_clr_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_dbg_i |=> !bits_o.dr && !bits_o.dw);

  p_line_tx_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_tx_i |=> !bits_o.r && !bits_o.w);

endmodule

// File: rtl/tracker_victim.sv
module tracker_victim #(
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned TAG_W     = 8,
  localparam int unsigned IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            acc_valid_i,
  input  logic [TAG_W-1:0]                acc_tag_i,
  input  logic [NUM_LINES-1:0]            valid_vec_i,
  input  logic [NUM_LINES-1:0][TAG_W-1:0] tag_vec_i,
  output logic                            hit_o,
  output logic [IDX_W-1:0]                hit_idx_o,
  output logic                            free_o,
  output logic [IDX_W-1:0]                free_idx_o,
  output logic [IDX_W-1:0]                victim_idx_o
);

  logic [NUM_LINES-1:0] hit_vec;
  logic [IDX_W-1:0]     rr_q;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_cmp
    assign hit_vec[i] = valid_vec_i[i] && (tag_vec_i[i] == acc_tag_i);
  end

  always_comb begin
    hit_idx_o  = '0;
    free_idx_o = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (hit_vec[i])         hit_idx_o  = IDX_W'(i);
      if (!valid_vec_i[i])    free_idx_o = IDX_W'(i);
    end
  end

  assign hit_o        = |hit_vec;
  assign free_o       = !(&valid_vec_i);
  assign victim_idx_o = rr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q <= '0;
    end else if (acc_valid_i && !hit_o && !free_o) begin
      rr_q <= (rr_q == IDX_W'(NUM_LINES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  p_unique_tag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));

endmodule

// File: rtl/dbg_access_tracker.sv
module dbg_access_tracker
  import tracker_pkg::*;
#(
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned TAG_W     = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_valid_i,
  input  logic             acc_write_i,
  input  logic [TAG_W-1:0] acc_tag_i,
  input  logic             cmd_valid_i,
  input  logic [2:0]       cmd_op_i,
  input  logic [TAG_W-1:0] probe_tag_i,
  output logic             probe_hit_o,
  output logic             probe_r_o,
  output logic             probe_w_o,
  output logic             probe_dr_o,
  output logic             probe_dw_o,
  output logic             tm_mode_o,
  output logic             dtm_mode_o,
  output logic             overflow_o,
  output logic             cmd_err_o,
  output logic             evict_o,
  output logic [TAG_W-1:0] evict_tag_o
);

  localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  logic                            dbg_active, clr_tx, clr_dbg;
  logic [NUM_LINES-1:0]            valid_vec;
  logic [NUM_LINES-1:0][TAG_W-1:0] tag_vec;
  acc_bits_t                       bits_vec [NUM_LINES];
  logic                            hit, free;
  logic [IDX_W-1:0]                hit_idx, free_idx, victim_idx, target_idx;
  acc_bits_t                       acc_set;
  logic [NUM_LINES-1:0]            probe_vec, rw_vec, dbg_vec;
  acc_bits_t                       probe_bits;

  tracker_mode_ctrl i_mode (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_op_i     (cmd_op_i),
    .tm_o         (tm_mode_o),
    .dtm_o        (dtm_mode_o),
    .dbg_active_o (dbg_active),
    .clr_tx_o     (clr_tx),
    .clr_dbg_o    (clr_dbg),
    .err_o        (cmd_err_o)
  );

  tracker_victim #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) i_victim (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .acc_valid_i  (acc_valid_i),
    .acc_tag_i    (acc_tag_i),
    .valid_vec_i  (valid_vec),
    .tag_vec_i    (tag_vec),
    .hit_o        (hit),
    .hit_idx_o    (hit_idx),
    .free_o       (free),
    .free_idx_o   (free_idx),
    .victim_idx_o (victim_idx)
  );

  assign target_idx = hit ? hit_idx : (free ? free_idx : victim_idx);

  always_comb begin
    acc_set.r  = !acc_write_i && tm_mode_o;
    acc_set.w  =  acc_write_i && tm_mode_o;
    acc_set.dr = !acc_write_i && dtm_mode_o;
    acc_set.dw =  acc_write_i && dtm_mode_o;
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic      sel;
    acc_bits_t line_bits;
    assign sel = acc_valid_i && (target_idx == IDX_W'(i));

    tracker_line #(.TAG_W(TAG_W)) i_line (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .alloc_i     (sel && !hit),
      .alloc_tag_i (acc_tag_i),
      .set_i       (sel ? acc_set : acc_bits_t'('0)),
      .clr_tx_i    (clr_tx),
      .clr_dbg_i   (clr_dbg),
      .valid_o     (valid_vec[i]),
      .tag_o       (tag_vec[i]),
      .bits_o      (line_bits)
    );

    assign bits_vec[i]  = line_bits;
    assign probe_vec[i] = valid_vec[i] && (tag_vec[i] == probe_tag_i);
    assign rw_vec[i]    = line_bits.r || line_bits.w;
    assign dbg_vec[i]   = line_bits.dr || line_bits.dw;
  end

  always_comb begin
    probe_bits = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (probe_vec[i]) probe_bits = bits_vec[i];
    end
  end

  assign probe_hit_o = |probe_vec;
  assign probe_r_o   = probe_bits.r;
  assign probe_w_o   = probe_bits.w;
  assign probe_dr_o  = probe_bits.dr;
  assign probe_dw_o  = probe_bits.dw;

  assign evict_o     = acc_valid_i && !hit && !free;
  assign evict_tag_o = tag_vec[victim_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      overflow_o <= 1'b0;
    end else if (clr_tx) begin
      overflow_o <= 1'b0;
    end else if (evict_o && rw_vec[victim_idx]) begin
      overflow_o <= 1'b1;
    end
  end

  p_probe_unique_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(probe_vec));

  p_ovf_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overflow_o) |-> $past(evict_o));

  p_ovf_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(overflow_o) |-> $past(cmd_valid_i && (cmd_op_i == 3'd1 || cmd_op_i == 3'd2)));

  p_dbg_idle_clean_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dbg_active |-> (dbg_vec == '0));

  p_tx_idle_clean_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tm_mode_o |-> (rw_vec == '0));

endmodule

// File: tb/test_dbg_access_tracker.sv
module test_dbg_access_tracker;

  localparam int unsigned TAG_W = 8;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             acc_valid_i = 1'b0, acc_write_i = 1'b0;
  logic [TAG_W-1:0] acc_tag_i = '0;
  logic             cmd_valid_i = 1'b0;
  logic [2:0]       cmd_op_i = '0;
  logic [TAG_W-1:0] probe_tag_i = '0;
  logic             probe_hit_o, probe_r_o, probe_w_o, probe_dr_o, probe_dw_o;
  logic             tm_mode_o, dtm_mode_o, overflow_o, cmd_err_o, evict_o;
  logic [TAG_W-1:0] evict_tag_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dbg_access_tracker #(.NUM_LINES(4), .TAG_W(TAG_W)) i_dbg_access_tracker (
    .clk_i(clk), .rst_ni(rst_ni),
    .acc_valid_i(acc_valid_i), .acc_write_i(acc_write_i), .acc_tag_i(acc_tag_i),
    .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i), .probe_tag_i(probe_tag_i),
    .probe_hit_o(probe_hit_o), .probe_r_o(probe_r_o), .probe_w_o(probe_w_o),
    .probe_dr_o(probe_dr_o), .probe_dw_o(probe_dw_o),
    .tm_mode_o(tm_mode_o), .dtm_mode_o(dtm_mode_o), .overflow_o(overflow_o),
    .cmd_err_o(cmd_err_o), .evict_o(evict_o), .evict_tag_o(evict_tag_o)
  );

  // {kind(0 idle,1 acc,2 cmd), wr, tag, op, hit, r w dr dw, tm dtm ov err}
  localparam int NV = 19;
  localparam logic [22:0] VEC [NV] = '{
    {2'd2, 1'b0, 8'h10, 3'd0, 1'b0, 4'b0000, 4'b1000}, // R3 tx begin
    {2'd1, 1'b0, 8'h10, 3'd0, 1'b1, 4'b1000, 4'b1000}, // R2 read
    {2'd1, 1'b1, 8'h11, 3'd0, 1'b1, 4'b0100, 4'b1000}, // R2 write
    {2'd2, 1'b0, 8'h11, 3'd3, 1'b1, 4'b0100, 4'b1100}, // R5 dbg begin
    {2'd1, 1'b0, 8'h12, 3'd0, 1'b1, 4'b1010, 4'b1100}, // R4 read
    {2'd1, 1'b1, 8'h10, 3'd0, 1'b1, 4'b1101, 4'b1100}, // R4 write
    {2'd2, 1'b0, 8'h10, 3'd5, 1'b1, 4'b1101, 4'b1000}, // R6 pause keeps
    {2'd1, 1'b1, 8'h13, 3'd0, 1'b1, 4'b0100, 4'b1000}, // R6 no new dbg
    {2'd2, 1'b0, 8'h12, 3'd6, 1'b1, 4'b1010, 4'b1100}, // R6 resume
    {2'd2, 1'b0, 8'h12, 3'd7, 1'b1, 4'b1000, 4'b1100}, // R7 clear
    {2'd1, 1'b0, 8'h14, 3'd0, 1'b1, 4'b1010, 4'b1110}, // R9 evict rw line
    {2'd2, 1'b0, 8'h14, 3'd1, 1'b1, 4'b0010, 4'b0100}, // R3 commit
    {2'd2, 1'b0, 8'h14, 3'd1, 1'b1, 4'b0010, 4'b0101}, // R11 commit w/o tx
    {2'd2, 1'b0, 8'h14, 3'd3, 1'b1, 4'b0010, 4'b0101}, // R11 double begin
    {2'd2, 1'b0, 8'h14, 3'd4, 1'b1, 4'b0000, 4'b0000}, // R5 end
    {2'd2, 1'b0, 8'h14, 3'd6, 1'b1, 4'b0000, 4'b0001}, // R11 resume idle
    {2'd1, 1'b1, 8'h15, 3'd0, 1'b1, 4'b0000, 4'b0000}, // R8 evict clean
    {2'd0, 1'b0, 8'h10, 3'd0, 1'b0, 4'b0000, 4'b0000}, // R8 replaced
    {2'd0, 1'b0, 8'h11, 3'd0, 1'b0, 4'b0000, 4'b0000}  // R8 replaced
  };

  function automatic string req_of(int i);
    case (i)
      0, 11:         return "R3";
      1, 2:          return "R2";
      3, 14:         return "R5";
      4, 5:          return "R4";
      6, 7, 8:       return "R6";
      9:             return "R7";
      10:            return "R9";
      12, 13, 15:    return "R11";
      default:       return "R8";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] observed();
    return {probe_hit_o, probe_r_o, probe_w_o, probe_dr_o, probe_dw_o,
            tm_mode_o, dtm_mode_o, overflow_o, cmd_err_o};
  endfunction

  // Starts and ends at a negedge with strobes low.
  task automatic step(int kind, logic wr, logic [7:0] tag, logic [2:0] op);
    acc_valid_i = (kind == 1);
    acc_write_i = wr;
    acc_tag_i   = tag;
    cmd_valid_i = (kind == 2);
    cmd_op_i    = op;
    @(negedge clk);
    acc_valid_i = 1'b0;
    cmd_valid_i = 1'b0;
  endtask

  task automatic probe(logic [7:0] tag);
    probe_tag_i = tag;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    probe(8'h00);
    chk("R1", {23'd0, observed()}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      step(int'(VEC[i][22:21]), VEC[i][20], VEC[i][19:12], VEC[i][11:9]);
      probe(VEC[i][19:12]);
      chk(req_of(i), {23'd0, observed()}, {23'd0, VEC[i][8:0]});
    end

    // Lines now: 0=14, 1=15, 2=12, 3=13, pointer at 2, all flags clear.
    step(2, 1'b0, 8'h00, 3'd3);
    acc_valid_i = 1'b1; acc_write_i = 1'b0; acc_tag_i = 8'h20;
    #1;
    chk("R8", {23'd0, evict_o, evict_tag_o}, {23'd0, 1'b1, 8'h12});
    @(negedge clk);
    acc_valid_i = 1'b0;
    probe(8'h20);
    chk("R4", {28'd0, probe_hit_o, probe_r_o, probe_dr_o, probe_dw_o}, 32'b1010);
    step(1, 1'b0, 8'h21, 3'd0);
    step(1, 1'b0, 8'h22, 3'd0);
    step(1, 1'b0, 8'h23, 3'd0);
    acc_valid_i = 1'b1; acc_write_i = 1'b0; acc_tag_i = 8'h24;
    #1;
    chk("R8", {23'd0, evict_o, evict_tag_o}, {23'd0, 1'b1, 8'h20});
    @(negedge clk);
    acc_valid_i = 1'b0;
    probe(8'h20);
    chk("R10", {30'd0, probe_hit_o, overflow_o}, 32'd0);

    // R12: debug end together with a store to a new line.
    step(2, 1'b0, 8'h00, 3'd0);
    acc_valid_i = 1'b1; acc_write_i = 1'b1; acc_tag_i = 8'h30;
    cmd_valid_i = 1'b1; cmd_op_i = 3'd4;
    @(negedge clk);
    acc_valid_i = 1'b0; cmd_valid_i = 1'b0;
    probe(8'h30);
    chk("R12", {27'd0, probe_hit_o, probe_w_o, probe_dw_o, dtm_mode_o, tm_mode_o},
        32'b11001);

    // R3: abort clears write flag and the transaction.
    step(2, 1'b0, 8'h00, 3'd2);
    probe(8'h30);
    chk("R3", {28'd0, probe_hit_o, probe_w_o, tm_mode_o, cmd_err_o}, 32'b1000);
    step(2, 1'b0, 8'h00, 3'd5);
    chk("R11", {30'd0, dtm_mode_o, cmd_err_o}, 32'b01);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule